// File: doc/BRIEF.md
# Binary Time-of-Day and Date Counter

This block keeps wall-clock time and a calendar date in a single 32-bit binary word. A 1 Hz enable pulse comes from elsewhere. Each pulse that arrives while the block is running moves the word forward one second. The carries ripple through minutes, hours, day of month, month and a 6-bit year offset. Month lengths are built in. Any year offset divisible by four is treated as a leap year, so the base year chosen by software must itself be a leap year.

Hours can be held in 24-hour form, or in 12-hour form with a PM indicator. The format can only be changed while the block is stopped. Software can load the whole word at any time and read it back continuously. When the full 64-year span rolls over, a sticky flag is raised, and software clears it by writing a one.

Top module: `cal_counter`

## Requirements
- R1: After synchronous reset, the word reads 0x00420000 (00:00:00, day 1, month 1, year 0), the overflow flag is 0 and the hour format is 24-hour.
- R2: The word packs sec[5:0], min[11:6], hour[16:12], day[21:17], month[25:22] and year[31:26]. While `run_en` is 1, each cycle with `tick` high advances the word by one second. With no tick, or with `run_en` at 0, the word does not change.
- R3: In 24-hour mode, seconds and minutes wrap from 59 to 0 and carry upward. 23:59:59 becomes 00:00:00 of the next day.
- R4: In 12-hour mode, hour[15:12] runs from 1 to 12 and hour[16] is 1 for PM. 11:59:59 AM becomes 12:00:00 PM on the same day. 11:59:59 PM becomes 12:00:00 AM of the next day. 12:59:59 becomes 1:00:00 in the same half of the day.
- R5: Months 4, 6, 9 and 11 have 30 days, February has 28 days in a non-leap year, and every other month has 31 days. After its last day a month moves on to day 1 of the next month.
- R6: In a year offset divisible by 4 (including 0), February has 29 days.
- R7: After 23:59:59 on December 31, the date becomes January 1 of the next year offset.
- R8: After 23:59:59 on December 31 of year 63, the word becomes 00:00:00 January 1 of year 0 and the overflow flag becomes 1. The flag is raised by nothing else.
- R9: The overflow flag stays set until a cycle with `ovf_clr` at 1 clears it. If a wrap and a clear fall in the same cycle, the flag ends up set.
- R10: A write to the hour format (`fmt_wr_en`, with 1 meaning 12-hour) takes effect only while `run_en` is 0. While running, such a write is ignored.
- R11: A cycle with `wr_en` high loads `wr_word` into the counter on the next edge. This happens even if a tick arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counter running |
| tick | input | 1 | One-cycle 1 Hz enable pulse |
| wr_en | input | 1 | Load the whole word |
| wr_word | input | 32 | Word to load |
| fmt_wr_en | input | 1 | Write the hour format |
| fmt_wr_12h | input | 1 | Format value: 1 for 12-hour, 0 for 24-hour |
| ovf_clr | input | 1 | Clear the overflow flag |
| cal_word | output | 32 | Current time and date |
| hour_12h | output | 1 | Current hour format |
| ovf_flag | output | 1 | Sticky 64-year rollover flag |

## Verification
On every cycle, the assertions check the following:
- A tick always changes the word, and an idle cycle leaves it alone.
- A load lands exactly.
- The format stays frozen while running.
- The flag stays sticky and rises only on an advancing tick.

Only the bench's scenarios can show that the carries are correct. This covers the hour crossings in both formats, every month end across leap and common years, and the wrap to year 0. The bench predicts each of these arithmetically from seconds-of-day and a month-length formula.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;
    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HOUR_W = 5;
    localparam int DAY_W  = 5;
    localparam int MON_W  = 4;
    localparam int YEAR_W = 6;
    localparam int WORD_W = SEC_W + MIN_W + HOUR_W + DAY_W + MON_W + YEAR_W;
    localparam int HR12_W = HOUR_W - 1;
    localparam logic [YEAR_W-1:0] YEAR_LAST = '1;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  min;
        logic [SEC_W-1:0]  sec;
    } cal_word_t;

    typedef enum logic {
        HFMT_24 = 1'b0,
        HFMT_12 = 1'b1
    } hour_fmt_e;

    localparam cal_word_t CAL_RESET = '{year: '0, month: MON_W'(1), day: DAY_W'(1),
                                        hour: '0, min: '0, sec: '0};

    function automatic logic [DAY_W-1:0] month_days(input logic [MON_W-1:0] m,
                                                   input logic [YEAR_W-1:0] y);
        if (m == MON_W'(2))
            return (y[1:0] == 2'b00) ? DAY_W'(29) : DAY_W'(28);
        if (m == MON_W'(4) || m == MON_W'(6) || m == MON_W'(9) || m == MON_W'(11))
            return DAY_W'(30);
        return DAY_W'(31);
    endfunction
endpackage

// File: rtl/cal_time_step.sv
`timescale 1ns/1ps
module cal_time_step
    import cal_pkg::*;
(
    input  cal_word_t cur_word,
    input  hour_fmt_e fmt,
    output cal_word_t time_word,
    output logic      day_carry
);
    logic [HR12_W-1:0] hr12;
    logic              pm;

    assign hr12 = cur_word.hour[HR12_W-1:0];
    assign pm   = cur_word.hour[HOUR_W-1];

    always_comb begin
        time_word = cur_word;
        day_carry = 1'b0;
        if (cur_word.sec >= SEC_W'(59)) begin
            time_word.sec = '0;
            if (cur_word.min >= MIN_W'(59)) begin
                time_word.min = '0;
                if (fmt == HFMT_24) begin
                    if (cur_word.hour >= HOUR_W'(23)) begin
                        time_word.hour = '0;
                        day_carry      = 1'b1;
                    end else begin
                        time_word.hour = cur_word.hour + HOUR_W'(1);
                    end
                end else begin
                    if (hr12 == HR12_W'(11)) begin
                        time_word.hour = {~pm, HR12_W'(12)};
                        day_carry      = pm;
                    end else if (hr12 >= HR12_W'(12)) begin
                        time_word.hour = {pm, HR12_W'(1)};
                    end else begin
                        time_word.hour = {pm, hr12 + HR12_W'(1)};
                    end
                end
            end else begin
                time_word.min = cur_word.min + MIN_W'(1);
            end
        end else begin
            time_word.sec = cur_word.sec + SEC_W'(1);
        end
    end
endmodule

// File: rtl/cal_date_step.sv
`timescale 1ns/1ps
module cal_date_step
    import cal_pkg::*;
(
    input  cal_word_t in_word,
    input  logic      day_carry,
    output cal_word_t next_word,
    output logic      range_wrap
);
    logic [DAY_W-1:0] last_day;

    assign last_day = month_days(in_word.month, in_word.year);

    always_comb begin
        next_word  = in_word;
        range_wrap = 1'b0;
        if (day_carry) begin
            if (in_word.day >= last_day) begin
                next_word.day = DAY_W'(1);
                if (in_word.month >= MON_W'(12)) begin
                    next_word.month = MON_W'(1);
                    if (in_word.year == YEAR_LAST) begin
                        next_word.year = '0;
                        range_wrap     = 1'b1;
                    end else begin
                        next_word.year = in_word.year + YEAR_W'(1);
                    end
                end else begin
                    next_word.month = in_word.month + MON_W'(1);
                end
            end else begin
                next_word.day = in_word.day + DAY_W'(1);
            end
        end
    end
endmodule

// File: rtl/cal_counter.sv
`timescale 1ns/1ps
module cal_counter
    import cal_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        run_en,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [31:0] wr_word,
    input  logic        fmt_wr_en,
    input  logic        fmt_wr_12h,
    input  logic        ovf_clr,
    output logic [31:0] cal_word,
    output logic        hour_12h,
    output logic        ovf_flag
);
    cal_word_t word_q;
    cal_word_t time_word;
    cal_word_t next_word;
    hour_fmt_e fmt_q;
    logic      ovf_q;
    logic      day_carry;
    logic      range_wrap;
    logic      advance;

    assign advance = run_en && tick && !wr_en;

    cal_time_step u_time (
        .cur_word  (word_q),
        .fmt       (fmt_q),
        .time_word (time_word),
        .day_carry (day_carry)
    );

    cal_date_step u_date (
        .in_word    (time_word),
        .day_carry  (day_carry),
        .next_word  (next_word),
        .range_wrap (range_wrap)
    );

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= CAL_RESET;
        else if (wr_en)
            word_q <= cal_word_t'(wr_word);
        else if (run_en && tick)
            word_q <= next_word;
    end

    always_ff @(posedge clk) begin
        if (rst)
            fmt_q <= HFMT_24;
        else if (fmt_wr_en && !run_en)
            fmt_q <= fmt_wr_12h ? HFMT_12 : HFMT_24;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (advance && range_wrap)
            ovf_q <= 1'b1;
        else if (ovf_clr)
            ovf_q <= 1'b0;
    end

    assign cal_word = word_q;
    assign hour_12h = (fmt_q == HFMT_12);
    assign ovf_flag = ovf_q;

    assert_tick_advance_R2: assert property (@(posedge clk) disable iff (rst)
        advance |=> cal_word != $past(cal_word));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !(run_en && tick)) |=> $stable(cal_word));

    assert_write_load_R11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cal_word == $past(wr_word));

    assert_fmt_lock_R10: assert property (@(posedge clk) disable iff (rst)
        run_en |=> $stable(hour_12h));

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    assert_ovf_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(advance));
endmodule

// File: tb/cal_counter_tb.sv
`timescale 1ns/1ps
module cal_counter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic        fmt_wr_en = 1'b0;
    logic        fmt_wr_12h = 1'b0;
    logic        ovf_clr = 1'b0;
    logic [31:0] cal_word;
    logic        hour_12h;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cal_counter u_dut (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .tick       (tick),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .fmt_wr_en  (fmt_wr_en),
        .fmt_wr_12h (fmt_wr_12h),
        .ovf_clr    (ovf_clr),
        .cal_word   (cal_word),
        .hour_12h   (hour_12h),
        .ovf_flag   (ovf_flag)
    );

    function automatic int mdays(int m, int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        return 30 + ((m + m / 8) % 2);
    endfunction

    function automatic logic [31:0] pack(int y, int mo, int d, int h, int mi, int s);
        return 32'((y << 26) | (mo << 22) | (d << 17) | (h << 12) | (mi << 6) | s);
    endfunction

    function automatic logic [31:0] model_next(logic [31:0] w, bit h12);
        int s, mi, h, d, mo, y, h24, sod, pm, hh;
        bit carry;
        s  = int'(w[5:0]);
        mi = int'(w[11:6]);
        h  = int'(w[16:12]);
        d  = int'(w[21:17]);
        mo = int'(w[25:22]);
        y  = int'(w[31:26]);
        h24 = h12 ? ((h % 16) % 12) + (h / 16) * 12 : h;
        sod = h24 * 3600 + mi * 60 + s + 1;
        carry = (sod == 86400);
        if (carry) sod = 0;
        h24 = sod / 3600;
        mi  = (sod / 60) % 60;
        s   = sod % 60;
        if (h12) begin
            pm = (h24 >= 12) ? 1 : 0;
            hh = h24 % 12;
            if (hh == 0) hh = 12;
            h = pm * 16 + hh;
        end else begin
            h = h24;
        end
        if (carry) begin
            d++;
            if (d > mdays(mo, y)) begin
                d = 1;
                mo++;
                if (mo > 12) begin
                    mo = 1;
                    y = (y + 1) % 64;
                end
            end
        end
        return pack(y, mo, d, h, mi, s);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_word(logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic fmt_write(bit v);
        @(negedge clk);
        fmt_wr_en = 1'b1;
        fmt_wr_12h = v;
        @(negedge clk);
        fmt_wr_en = 1'b0;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 word", cal_word, 32'h0042_0000);
        chk("R1 ovf", {31'b0, ovf_flag}, 32'd0);
        chk("R1 fmt", {31'b0, hour_12h}, 32'd0);

        // R2: tick ignored while stopped
        tick1();
        chk("R2 stopped", cal_word, 32'h0042_0000);
        run_en = 1'b1;
        @(negedge clk);
        chk("R2 no tick", cal_word, 32'h0042_0000);

        // R10: format write ignored while running
        fmt_write(1'b1);
        chk("R10 locked", {31'b0, hour_12h}, 32'd0);

        // R3 / R2: continuous 24-hour sweep across midnight and Feb end
        exp = pack(1, 2, 28, 22, 59, 0);
        put_word(exp);
        chk("R11 load", cal_word, exp);
        for (int i = 0; i < 4000; i++) begin
            tick1();
            exp = model_next(exp, 1'b0);
            chk("R3 sweep", cal_word, exp);
        end

        // R5/R6/R7: every month end, leap and common years
        for (int yi = 0; yi < 11; yi++) begin
            int y;
            y = (yi < 8) ? yi : 52 + yi;
            for (int m = 1; m <= 12; m++) begin
                exp = pack(y, m, mdays(m, y), 23, 59, 59);
                put_word(exp);
                tick1();
                chk(m == 12 ? "R7 year end" : (m == 2 ? "R6 feb end" : "R5 month end"),
                    cal_word, model_next(exp, 1'b0));
            end
            exp = pack(y, 2, 28, 23, 59, 59);
            put_word(exp);
            tick1();
            chk("R6 feb 28", cal_word, (y % 4 == 0) ? pack(y, 2, 29, 0, 0, 0)
                                                      : pack(y, 3, 1, 0, 0, 0));
        end

        // R10: format write accepted while stopped
        run_en = 1'b0;
        fmt_write(1'b1);
        chk("R10 accepted", {31'b0, hour_12h}, 32'd1);
        run_en = 1'b1;

        // R4: every hour crossing in 12-hour form
        for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
                exp = pack(5, 3, 10, pm * 16 + h, 59, 59);
                put_word(exp);
                tick1();
                chk("R4 hour", cal_word, model_next(exp, 1'b1));
            end
        end
        put_word(pack(5, 3, 10, 27, 59, 59));
        tick1();
        chk("R4 11pm", cal_word, pack(5, 3, 11, 12, 0, 0));

        // R8: full range wrap in 12-hour form
        put_word(pack(63, 12, 31, 27, 59, 59));
        chk("R8 pre", {31'b0, ovf_flag}, 32'd0);
        tick1();
        chk("R8 wrap word", cal_word, pack(0, 1, 1, 12, 0, 0));
        chk("R8 flag", {31'b0, ovf_flag}, 32'd1);
        tick1();
        chk("R9 sticky", {31'b0, ovf_flag}, 32'd1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9 clear", {31'b0, ovf_flag}, 32'd0);

        // R9: wrap and clear together leaves the flag set
        put_word(pack(63, 12, 31, 27, 59, 59));
        @(negedge clk);
        tick = 1'b1;
        ovf_clr = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        ovf_clr = 1'b0;
        chk("R9 set wins", {31'b0, ovf_flag}, 32'd1);

        // R11: load beats a tick in the same cycle
        @(negedge clk);
        wr_en = 1'b1;
        tick = 1'b1;
        wr_word = pack(9, 7, 4, 3, 2, 1);
        @(negedge clk);
        wr_en = 1'b0;
        tick = 1'b0;
        chk("R11 priority", cal_word, pack(9, 7, 4, 3, 2, 1));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule